// File: doc/BRIEF.md
# Power-Good Latched Frequency Selector

This block takes a four-pin frequency-select strap and freezes it at power-up. A processor-side power-good signal is active low. The first time that signal is seen low on two consecutive synchronised cycles, the block captures the synchronised strap value as a 4-bit code. It then ignores every later movement of the strap pins and of power-good until the next reset.

The captured code indexes a small constant table. The table gives the multiplier and divider settings for the CPU clock synthesiser. The settings for the PCIe synthesiser are the same for every code. A valid flag tells downstream PLL control logic when the code and the settings can be used.

A test-mode strap removes the one-shot lock. While test mode is high, the code keeps following the pins whenever power-good is held low. All pins are asynchronous to the block clock and pass through two-flop synchronisers. The reset is asserted asynchronously and released synchronously.

Top module: `pfl_top`

## Requirements
- R1: While reset is asserted, and after it is released with no capture yet, `code` is 0, `valid` is 0, and the settings are those of entry 0: CPU M=60, N=200 and PCIe M=30, N=60.
- R2: When `pg_n` falls and stays low while the strap is stable, `code` takes the strap value on the 4th rising edge after the fall and not earlier. The bit mapping is `fsel[0]`=A, `fsel[1]`=B, `fsel[2]`=C and `fsel[3]`=D, which become code bits 0 to 3.
- R3: `valid` rises on the 5th rising edge after `pg_n` falls. That is one cycle after the capture. It then stays high until reset.
- R4: A low pulse on `pg_n` that lasts only one clock cycle captures nothing: `code` and `valid` stay 0.
- R5: After a capture with test mode low, later changes on `fsel` and on `pg_n` have no effect on `code` or on the settings.
- R6: With `test_mode` high and `pg_n` held low, a change on `fsel` appears on `code` on the 3rd rising edge after the change. With `pg_n` high, the strap is not tracked even in test mode.
- R7: The CPU settings are registered one cycle behind `code`. Codes whose low three bits are 3 or 4 give M=63, N=175. Codes whose low three bits are 7 give M=60, N=250. All other codes give M=60, N=200.
- R8: The PCIe settings are M=30, N=60 for every code.
- R9: Asserting reset clears the code, the lock and the valid flag at once. After reset is released, a new power-good fall captures a new strap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel | input | 4 | Frequency-select strap pins, bit 0 = A to bit 3 = D |
| pg_n | input | 1 | Active-low power-good |
| test_mode | input | 1 | Bypasses the one-shot lock when high |
| code | output | 4 | Latched frequency code |
| valid | output | 1 | Code and settings are usable |
| cpu_mult | output | 8 | CPU PLL multiplier M |
| cpu_div | output | 8 | CPU PLL divider N |
| pcie_mult | output | 8 | PCIe PLL multiplier M |
| pcie_div | output | 8 | PCIe PLL divider N |

## Verification
The path from a power-good fall to a capture has four registers: two synchroniser stages, the confirmation flop and the code register. So `code` is due on the 4th rising edge, and `valid` and the CPU settings are due on the 5th. In test mode a strap change crosses only three registers, because the confirmation is already satisfied. The bench drives each input just after a falling edge and samples 1 ns after the counted rising edge. It checks both the cycle before each result is due, where the old value must still hold, and the cycle where it is due. Checks that something is ignored wait at least ten cycles, so that any effect would have had time to reach the outputs.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int CODE_W = 4;
  localparam int CFG_W  = 8;

  typedef struct packed {
    logic [CFG_W-1:0] cpu_m;
    logic [CFG_W-1:0] cpu_n;
    logic [CFG_W-1:0] pcie_m;
    logic [CFG_W-1:0] pcie_n;
  } pll_cfg_t;

  // Constant settings table, computed from the low three code bits
  function automatic pll_cfg_t cfg_lookup(input logic [CODE_W-1:0] c);
    pll_cfg_t r;
    r.pcie_m = CFG_W'(30);
    r.pcie_n = CFG_W'(60);
    case (c[2:0])
      3'd3, 3'd4: begin r.cpu_m = CFG_W'(63); r.cpu_n = CFG_W'(175); end
      3'd7:       begin r.cpu_m = CFG_W'(60); r.cpu_n = CFG_W'(250); end
      default:    begin r.cpu_m = CFG_W'(60); r.cpu_n = CFG_W'(200); end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pfl_rst_sync.sv
module pfl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfl_sync.sv
module pfl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pfl_capture.sv
module pfl_capture
  import pfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_n_s,
  input  logic [CODE_W-1:0] fsel_s,
  input  logic              tm_s,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  logic              pg_d_q;
  logic              lock_q, lock_d;
  logic              valid_q, valid_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              pg_ok;
  logic              cap_en;

  // power-good counts only when low on two consecutive synchronised cycles
  always_comb begin
    pg_ok   = !pg_n_s && !pg_d_q;
    cap_en  = pg_ok && (!lock_q || tm_s);
    code_d  = cap_en ? fsel_s : code_q;
    lock_d  = lock_q | cap_en;
    valid_d = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d_q  <= 1'b1;
      lock_q  <= 1'b0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      pg_d_q  <= pg_n_s;
      lock_q  <= lock_d;
      valid_q <= valid_q | valid_d;
      if (cap_en) code_q <= code_d;
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q); // R3
  AST_LOCK_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> valid_q); // R3
  AST_LOCK_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !tm_s) |=> $stable(code_q)); // R5
  AST_NO_CAPTURE_WITHOUT_PG: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_n_s || pg_d_q) |=> $stable(code_q)); // R4
endmodule

// File: rtl/pfl_cfg_rom.sv
module pfl_cfg_rom
  import pfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output pll_cfg_t          cfg_o
);
  pll_cfg_t cfg_q, cfg_d;

  always_comb cfg_d = cfg_lookup(code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= cfg_lookup('0);
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_CPU_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.cpu_n == 8'd175) || (cfg_q.cpu_n == 8'd200) || (cfg_q.cpu_n == 8'd250)); // R7
endmodule

// File: rtl/pfl_top.sv
module pfl_top
  import pfl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fsel,
  input  logic              pg_n,
  input  logic              test_mode,
  output logic [CODE_W-1:0] code,
  output logic              valid,
  output logic [CFG_W-1:0]  cpu_mult,
  output logic [CFG_W-1:0]  cpu_div,
  output logic [CFG_W-1:0]  pcie_mult,
  output logic [CFG_W-1:0]  pcie_div
);
  localparam int PIN_W = CODE_W + 2;
  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << (PIN_W-1);

  logic             rst_sync_n;
  logic [PIN_W-1:0] pins_raw, pins_s;
  pll_cfg_t         cfg;

  pfl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n));

  assign pins_raw = {pg_n, test_mode, fsel};

  pfl_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pins_raw), .q(pins_s));

  pfl_capture u_cap (
    .clk(clk), .rst_n(rst_sync_n),
    .pg_n_s(pins_s[PIN_W-1]), .fsel_s(pins_s[CODE_W-1:0]), .tm_s(pins_s[CODE_W]),
    .code_o(code), .valid_o(valid));

  pfl_cfg_rom u_rom (
    .clk(clk), .rst_n(rst_sync_n), .code_i(code), .cfg_o(cfg));

  assign cpu_mult  = cfg.cpu_m;
  assign cpu_div   = cfg.cpu_n;
  assign pcie_mult = cfg.pcie_m;
  assign pcie_div  = cfg.pcie_n;
endmodule

// File: tb/tb_pfl_top.sv
module tb_pfl_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] fsel;
  logic       pg_n;
  logic       test_mode;
  logic [3:0] code;
  logic       valid;
  logic [7:0] cpu_mult, cpu_div, pcie_mult, pcie_div;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfl_top dut (.clk(clk), .rst_n(rst_n), .fsel(fsel), .pg_n(pg_n),
    .test_mode(test_mode), .code(code), .valid(valid), .cpu_mult(cpu_mult),
    .cpu_div(cpu_div), .pcie_mult(pcie_mult), .pcie_div(pcie_div));

  function automatic int exp_m(input logic [3:0] c);
    return (c[2:0] == 3'd3 || c[2:0] == 3'd4) ? 63 : 60;
  endfunction
  function automatic int exp_n(input logic [3:0] c);
    if (c[2:0] == 3'd3 || c[2:0] == 3'd4) return 175;
    if (c[2:0] == 3'd7) return 250;
    return 200;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pg_n = 1'b1; test_mode = 1'b0;
    edges(3);
    @(negedge clk);
    rst_n = 1'b1;
    edges(5);
  endtask

  task automatic capture(input logic [3:0] c);
    @(negedge clk); fsel = c;
    edges(4);
    @(negedge clk); pg_n = 1'b0;
    edges(8);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "code", code, 0);
    chk("R1", "valid", valid, 0);
    chk("R1", "cpu_mult", cpu_mult, 60);
    chk("R1", "cpu_div", cpu_div, 200);
    chk("R1", "pcie_mult", pcie_mult, 30);
    chk("R1", "pcie_div", pcie_div, 60);
  endtask

  task automatic t_capture_timing();
    do_reset();
    @(negedge clk); fsel = 4'b1011;
    edges(4);
    @(negedge clk); pg_n = 1'b0;
    edges(3);
    chk("R2", "code before due", code, 0);
    edges(1);
    chk("R2", "code at 4th edge", code, 11);
    chk("R3", "valid at 4th edge", valid, 0);
    edges(1);
    chk("R3", "valid at 5th edge", valid, 1);
    chk("R7", "cpu_mult code 11", cpu_mult, exp_m(4'd11));
    chk("R7", "cpu_div code 11", cpu_div, exp_n(4'd11));
    edges(20);
    chk("R3", "valid sticky", valid, 1);
  endtask

  task automatic t_glitch();
    do_reset();
    @(negedge clk); fsel = 4'b0110;
    edges(4);
    @(negedge clk); pg_n = 1'b0;
    @(negedge clk); pg_n = 1'b1;
    edges(10);
    chk("R4", "code after pulse", code, 0);
    chk("R4", "valid after pulse", valid, 0);
  endtask

  task automatic t_lock();
    do_reset();
    capture(4'hA);
    chk("R5", "captured code", code, 10);
    @(negedge clk); fsel = 4'h3; pg_n = 1'b1;
    edges(6);
    @(negedge clk); pg_n = 1'b0; fsel = 4'h4;
    edges(12);
    chk("R5", "code after pin changes", code, 10);
    chk("R5", "cpu_mult held", cpu_mult, exp_m(4'hA));
    chk("R5", "cpu_div held", cpu_div, exp_n(4'hA));
    chk("R5", "valid held", valid, 1);
  endtask

  task automatic t_test_mode();
    do_reset();
    @(negedge clk); test_mode = 1'b1;
    capture(4'h5);
    chk("R6", "first code", code, 5);
    @(negedge clk); fsel = 4'h9;
    edges(2);
    chk("R6", "code before due", code, 5);
    edges(1);
    chk("R6", "code tracks at 3rd edge", code, 9);
    edges(2);
    chk("R7", "cpu_div follows", cpu_div, exp_n(4'h9));
    @(negedge clk); pg_n = 1'b1;
    edges(6);
    @(negedge clk); fsel = 4'h2;
    edges(10);
    chk("R6", "no tracking with pg high", code, 9);
  endtask

  task automatic t_reset_relock();
    do_reset();
    capture(4'h7);
    chk("R9", "first capture", code, 7);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R9", "code cleared async", code, 0);
    chk("R9", "valid cleared async", valid, 0);
    edges(3);
    @(negedge clk); rst_n = 1'b1; pg_n = 1'b1;
    edges(5);
    capture(4'hC);
    chk("R9", "new capture", code, 12);
    chk("R9", "valid again", valid, 1);
  endtask

  task automatic t_table_sweep();
    for (int c = 0; c < 16; c++) begin
      do_reset();
      capture(4'(c));
      chk("R2", "swept code", code, c);
      chk("R7", "swept cpu_mult", cpu_mult, exp_m(4'(c)));
      chk("R7", "swept cpu_div", cpu_div, exp_n(4'(c)));
      chk("R8", "swept pcie_mult", pcie_mult, 30);
      chk("R8", "swept pcie_div", pcie_div, 60);
    end
  endtask

  initial begin
    rst_n = 1'b0; fsel = '0; pg_n = 1'b1; test_mode = 1'b0;
    t_reset_state();
    t_capture_timing();
    t_glitch();
    t_lock();
    t_test_mode();
    t_reset_relock();
    t_table_sweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule